// File: doc/BRIEF.md
# ADC conversion flag and interrupt controller

This block keeps the bookkeeping that sits between a multi-slot ADC sequencer and software. Each conversion slot owns one complete flag. A conversion that is accepted sets its flag. When compare is enabled for the slot, the flag sets only if the compare matched. A separate sequence flag marks the end of a sequence. Two level interrupt requests are formed from the flags and their enables. Flags clear in one of three ways, chosen by a fast-clear control and by the slot's compare enable: a write-one-to-clear strobe on the flag vector, a read of the slot's result register, or a write to the slot's result register.

A small mode state machine follows the low-power stop indication through five states: Run, Enter, StopConvert, StopHalt and Exit. The transitions are named as follows:
- *Sleep*: Run to Enter, when stop is requested.
- *Keep*: Enter to StopConvert, when continue-in-stop is set.
- *Park*: Enter to StopHalt, when continue-in-stop is clear.
- *Wake*: StopConvert or StopHalt to Exit, when the stop request drops.
- *Resume*: Exit to Run.

Conversions that finish in Enter or Exit fall across a clock change. They are dropped: no result write, no compare, no flag. In StopHalt, a sequence that was running is aborted, and a restart is requested on the way out.

Top module: `adc_flag_ctrl`

## Requirements
- R1: After reset, every slot flag, the sequence flag, both interrupt requests, `seq_abort` and `seq_restart` are 0, and the mode machine is in Run.
- R2: A conversion is accepted when `conv_done` is high in Run or StopConvert. `res_we` is high in that same cycle. If compare is disabled for slot `conv_idx`, bit `conv_idx` of `flags` is 1 from the next cycle on. Bit n of `flags` belongs to slot n, and no other bit changes.
- R3: With `fast_clr` low, a cycle with `flag_wr` high clears every flag whose `flag_wdata` bit is 1. `reg_rd` and `reg_wr` clear nothing in this mode.
- R4: With `fast_clr` high and `cmp_en[n]` low, a `reg_rd` with `reg_idx` = n clears flag n. `reg_wr` and `flag_wr` leave it set.
- R5: With `fast_clr` high and `cmp_en[n]` high, a `reg_wr` with `reg_idx` = n clears flag n. `reg_rd` leaves it set.
- R6: With `cmp_en[n]` high, an accepted conversion of slot n sets flag n only when `cmp_match` is 1.
- R7: When a set and a clear reach the same flag in one cycle, the flag ends up 1.
- R8: An accepted conversion with `conv_last` high sets `seq_flag` in the next cycle. `seq_start` clears it. If both occur in one cycle, the flag is set.
- R9: In the same cycle, `cmp_irq` is high exactly when `cmp_ie` is 1 and some flag n with `cmp_en[n]` = 1 is set. `seq_irq` is high exactly when `seq_ie` and `seq_flag` are both 1.
- R10: A `conv_done` in Enter or Exit is discarded. `res_we` stays low, and neither `flags` nor `seq_flag` changes.
- R11: With `cont_in_stop` low, conversions in StopHalt are discarded. `seq_abort` is high in Enter if a sequence is active (started and its last conversion not yet accepted). `seq_restart` is high for the Exit cycle that follows such an abort, and stays low otherwise.
- R12: With `cont_in_stop` high, conversions in StopConvert are accepted and set flags as in Run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| conv_done | input | 1 | A conversion finished this cycle |
| conv_idx | input | IDX_W | Slot of the finished conversion |
| cmp_match | input | 1 | Compare result for the finished conversion |
| conv_last | input | 1 | Finished conversion is the last of its sequence |
| seq_start | input | 1 | A new sequence starts |
| cmp_en | input | N_CONV | Per-slot compare enable |
| flag_wr | input | 1 | Write strobe to the flag vector (write one to clear) |
| flag_wdata | input | N_CONV | Data of the flag vector write |
| reg_rd | input | 1 | Result register read strobe |
| reg_wr | input | 1 | Result register write strobe |
| reg_idx | input | IDX_W | Decoded result register slot |
| fast_clr | input | 1 | Selects clear by result register access |
| cmp_ie | input | 1 | Compare interrupt enable |
| seq_ie | input | 1 | Sequence interrupt enable |
| stop_mode | input | 1 | Low-power stop requested |
| cont_in_stop | input | 1 | Keep converting in stop |
| flags | output | N_CONV | Per-slot complete flags |
| seq_flag | output | 1 | Sequence complete flag |
| cmp_irq | output | 1 | Compare interrupt request |
| seq_irq | output | 1 | Sequence interrupt request |
| res_we | output | 1 | Result of this conversion is valid to store |
| seq_abort | output | 1 | Running sequence aborted on stop entry |
| seq_restart | output | 1 | Aborted sequence must restart |

## Verification
Each of the sixteen slots is swept under each clear mode: write-one-to-clear, clear on read and clear on write. At every slot, the access that should clear is applied next to the accesses that must not, so a wrong slot decode or a swapped mode shows up as a stray cleared or surviving bit. The compare sweep uses a mask that splits the slots in halves and tries both match values at every slot. It tells the compare gating apart from plain completion, and it shows whether the compare interrupt looks only at compare-enabled flags. The stop sweeps put a conversion in each of the five mode states, with and without continue-in-stop and with and without an active sequence, which separates discarded conversions from accepted ones and a genuine abort and restart from a spurious one.

// File: rtl/adc_flag_pkg.sv
package adc_flag_pkg;

    // Mode of the converter with respect to low-power stop.
    typedef enum logic [2:0] {
        MS_RUN       = 3'd0,
        MS_ENTER     = 3'd1,
        MS_STOP_CONV = 3'd2,
        MS_STOP_HALT = 3'd3,
        MS_EXIT      = 3'd4
    } mode_e;

endpackage

// File: rtl/adc_mode_fsm.sv
module adc_mode_fsm
    import adc_flag_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  stop_mode,
    input  logic  cont_in_stop,
    input  logic  seq_start,
    input  logic  last_accept,
    output mode_e state,
    output logic  conv_window,
    output logic  seq_abort,
    output logic  seq_restart
);

    mode_e state_q;
    mode_e state_d;
    logic  abort_pend_q;
    logic  seq_active_q;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= MS_RUN;
        end else begin
            state_q <= state_d;
        end
    end

    // Next state: Sleep, Keep, Park, Wake, Resume
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            MS_RUN: begin
                if (stop_mode) begin
                    state_d = MS_ENTER;
                end
            end
            MS_ENTER: begin
                state_d = cont_in_stop ? MS_STOP_CONV : MS_STOP_HALT;
            end
            MS_STOP_CONV, MS_STOP_HALT: begin
                if (!stop_mode) begin
                    state_d = MS_EXIT;
                end
            end
            MS_EXIT: begin
                state_d = MS_RUN;
            end
            default: begin
                state_d = MS_RUN;
            end
        endcase
    end

    // Outputs decoded from the state
    always_comb begin
        conv_window = 1'b0;
        seq_abort   = 1'b0;
        seq_restart = 1'b0;
        unique case (state_q)
            MS_RUN:       conv_window = 1'b1;
            MS_STOP_CONV: conv_window = 1'b1;
            MS_ENTER:     seq_abort   = !cont_in_stop && seq_active_q;
            MS_EXIT:      seq_restart = abort_pend_q;
            MS_STOP_HALT: conv_window = 1'b0;
            default:      conv_window = 1'b0;
        endcase
    end

    // Sequence activity and pending restart
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            abort_pend_q <= 1'b0;
            seq_active_q <= 1'b0;
        end else begin
            if (seq_abort) begin
                abort_pend_q <= 1'b1;
            end else if (state_q == MS_EXIT) begin
                abort_pend_q <= 1'b0;
            end

            if (seq_abort) begin
                seq_active_q <= 1'b0;
            end else if (seq_start) begin
                seq_active_q <= 1'b1;
            end else if (last_accept) begin
                seq_active_q <= 1'b0;
            end
        end
    end

    assign state = state_q;

endmodule

// File: rtl/adc_flag_bank.sv
module adc_flag_bank #(
    parameter int N_CONV = 16,
    parameter int IDX_W  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              accept,
    input  logic [IDX_W-1:0]  conv_idx,
    input  logic              cmp_match,
    input  logic [N_CONV-1:0] cmp_en,
    input  logic              fast_clr,
    input  logic              flag_wr,
    input  logic [N_CONV-1:0] flag_wdata,
    input  logic              reg_rd,
    input  logic              reg_wr,
    input  logic [IDX_W-1:0]  reg_idx,
    output logic [N_CONV-1:0] flags
);

    for (genvar g = 0; g < N_CONV; g++) begin : g_slot
        localparam logic [IDX_W-1:0] SLOT = IDX_W'(g);

        logic hit_set;
        logic hit_clr;
        logic bit_q;

        always_comb begin
            hit_set = accept && (conv_idx == SLOT) && (!cmp_en[g] || cmp_match);
            if (!fast_clr) begin
                hit_clr = flag_wr && flag_wdata[g];
            end else if (cmp_en[g]) begin
                hit_clr = reg_wr && (reg_idx == SLOT);
            end else begin
                hit_clr = reg_rd && (reg_idx == SLOT);
            end
        end

        // Set has priority over clear
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                bit_q <= 1'b0;
            end else if (hit_set) begin
                bit_q <= 1'b1;
            end else if (hit_clr) begin
                bit_q <= 1'b0;
            end
        end

        assign flags[g] = bit_q;
    end

endmodule

// File: rtl/adc_seq_irq.sv
module adc_seq_irq #(
    parameter int N_CONV = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              last_accept,
    input  logic              seq_start,
    input  logic [N_CONV-1:0] flags,
    input  logic [N_CONV-1:0] cmp_en,
    input  logic              cmp_ie,
    input  logic              seq_ie,
    output logic              seq_flag,
    output logic              cmp_irq,
    output logic              seq_irq
);

    logic seq_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seq_q <= 1'b0;
        end else if (last_accept) begin
            seq_q <= 1'b1;
        end else if (seq_start) begin
            seq_q <= 1'b0;
        end
    end

    always_comb begin
        seq_flag = seq_q;
        cmp_irq  = cmp_ie && (|(flags & cmp_en));
        seq_irq  = seq_ie && seq_q;
    end

endmodule

// File: rtl/adc_flag_ctrl.sv
module adc_flag_ctrl
    import adc_flag_pkg::*;
#(
    parameter int N_CONV = 16,
    localparam int IDX_W = (N_CONV > 1) ? $clog2(N_CONV) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              conv_done,
    input  logic [IDX_W-1:0]  conv_idx,
    input  logic              cmp_match,
    input  logic              conv_last,
    input  logic              seq_start,
    input  logic [N_CONV-1:0] cmp_en,
    input  logic              flag_wr,
    input  logic [N_CONV-1:0] flag_wdata,
    input  logic              reg_rd,
    input  logic              reg_wr,
    input  logic [IDX_W-1:0]  reg_idx,
    input  logic              fast_clr,
    input  logic              cmp_ie,
    input  logic              seq_ie,
    input  logic              stop_mode,
    input  logic              cont_in_stop,
    output logic [N_CONV-1:0] flags,
    output logic              seq_flag,
    output logic              cmp_irq,
    output logic              seq_irq,
    output logic              res_we,
    output logic              seq_abort,
    output logic              seq_restart
);

    mode_e mode_state;
    logic  conv_window;
    logic  accept;
    logic  last_accept;

    assign accept      = conv_done && conv_window;
    assign last_accept = accept && conv_last;
    assign res_we      = accept;

    adc_mode_fsm u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .stop_mode    (stop_mode),
        .cont_in_stop (cont_in_stop),
        .seq_start    (seq_start),
        .last_accept  (last_accept),
        .state        (mode_state),
        .conv_window  (conv_window),
        .seq_abort    (seq_abort),
        .seq_restart  (seq_restart)
    );

    adc_flag_bank #(
        .N_CONV (N_CONV),
        .IDX_W  (IDX_W)
    ) u_bank (
        .clk        (clk),
        .rst_n      (rst_n),
        .accept     (accept),
        .conv_idx   (conv_idx),
        .cmp_match  (cmp_match),
        .cmp_en     (cmp_en),
        .fast_clr   (fast_clr),
        .flag_wr    (flag_wr),
        .flag_wdata (flag_wdata),
        .reg_rd     (reg_rd),
        .reg_wr     (reg_wr),
        .reg_idx    (reg_idx),
        .flags      (flags)
    );

    adc_seq_irq #(
        .N_CONV (N_CONV)
    ) u_irq (
        .clk         (clk),
        .rst_n       (rst_n),
        .last_accept (last_accept),
        .seq_start   (seq_start),
        .flags       (flags),
        .cmp_en      (cmp_en),
        .cmp_ie      (cmp_ie),
        .seq_ie      (seq_ie),
        .seq_flag    (seq_flag),
        .cmp_irq     (cmp_irq),
        .seq_irq     (seq_irq)
    );

endmodule

// File: rtl/adc_flag_ctrl_chk.sv
module adc_flag_ctrl_chk
    import adc_flag_pkg::*;
#(
    parameter int N_CONV = 16,
    parameter int IDX_W  = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              conv_done,
    input logic [IDX_W-1:0]  conv_idx,
    input logic              cmp_match,
    input logic [N_CONV-1:0] cmp_en,
    input logic              fast_clr,
    input logic              flag_wr,
    input logic              cmp_ie,
    input logic              seq_ie,
    input logic              cont_in_stop,
    input mode_e             state,
    input logic [N_CONV-1:0] flags,
    input logic              seq_flag,
    input logic              cmp_irq,
    input logic              seq_irq,
    input logic              res_we,
    input logic              seq_abort,
    input logic              seq_restart
);

    // R2: accepted conversion without compare sets its slot
    a_r2_plain_set: assert property (@(posedge clk) disable iff (!rst_n)
        (res_we && !cmp_en[conv_idx]) |=> flags[$past(conv_idx)]);

    // R6: compare miss raises no flag
    a_r6_miss_no_rise: assert property (@(posedge clk) disable iff (!rst_n)
        (conv_done && cmp_en[conv_idx] && !cmp_match) |=> ((flags & ~$past(flags)) == '0));

    // R10: transition states raise nothing
    a_r10_transition_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (state == MS_ENTER || state == MS_EXIT) |=>
            (((flags & ~$past(flags)) == '0) && !$rose(seq_flag)));

    // R11: halted stop stores no result
    a_r11_halt_no_store: assert property (@(posedge clk) disable iff (!rst_n)
        (state == MS_STOP_HALT) |-> !res_we);

    // R3: without a flag write, legacy mode never drops a flag
    a_r3_hold_without_write: assert property (@(posedge clk) disable iff (!rst_n)
        (!fast_clr && !flag_wr) |=> ((~flags & $past(flags)) == '0));

    // R9: requests need their enables
    a_r9_cmp_irq_enabled: assert property (@(posedge clk) disable iff (!rst_n)
        cmp_irq |-> cmp_ie);
    a_r9_seq_irq_enabled: assert property (@(posedge clk) disable iff (!rst_n)
        seq_irq |-> (seq_ie && seq_flag));

    // R11: abort only on entry, restart only after a halt
    a_r11_abort_on_entry: assert property (@(posedge clk) disable iff (!rst_n)
        seq_abort |-> (state == MS_ENTER && !cont_in_stop));
    a_r11_restart_after_halt: assert property (@(posedge clk) disable iff (!rst_n)
        seq_restart |-> ($past(state) == MS_STOP_HALT));

endmodule

bind adc_flag_ctrl adc_flag_ctrl_chk #(
    .N_CONV (N_CONV),
    .IDX_W  (IDX_W)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .conv_done    (conv_done),
    .conv_idx     (conv_idx),
    .cmp_match    (cmp_match),
    .cmp_en       (cmp_en),
    .fast_clr     (fast_clr),
    .flag_wr      (flag_wr),
    .cmp_ie       (cmp_ie),
    .seq_ie       (seq_ie),
    .cont_in_stop (cont_in_stop),
    .state        (mode_state),
    .flags        (flags),
    .seq_flag     (seq_flag),
    .cmp_irq      (cmp_irq),
    .seq_irq      (seq_irq),
    .res_we       (res_we),
    .seq_abort    (seq_abort),
    .seq_restart  (seq_restart)
);

// File: tb/tb_adc_flag_ctrl.sv
`timescale 1ns/1ps
module tb_adc_flag_ctrl;

    localparam int N  = 16;
    localparam int IW = 4;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          conv_done, cmp_match, conv_last, seq_start;
    logic [IW-1:0] conv_idx, reg_idx;
    logic [N-1:0]  cmp_en, flag_wdata;
    logic          flag_wr, reg_rd, reg_wr, fast_clr, cmp_ie, seq_ie;
    logic          stop_mode, cont_in_stop;
    logic [N-1:0]  flags;
    logic          seq_flag, cmp_irq, seq_irq, res_we, seq_abort, seq_restart;

    int checks = 0;
    int errors = 0;
    logic [N-1:0] exp_f;

    always #5 clk = ~clk;

    adc_flag_ctrl #(.N_CONV(N)) dut (
        .clk(clk), .rst_n(rst_n), .conv_done(conv_done), .conv_idx(conv_idx),
        .cmp_match(cmp_match), .conv_last(conv_last), .seq_start(seq_start),
        .cmp_en(cmp_en), .flag_wr(flag_wr), .flag_wdata(flag_wdata),
        .reg_rd(reg_rd), .reg_wr(reg_wr), .reg_idx(reg_idx),
        .fast_clr(fast_clr), .cmp_ie(cmp_ie), .seq_ie(seq_ie),
        .stop_mode(stop_mode), .cont_in_stop(cont_in_stop),
        .flags(flags), .seq_flag(seq_flag), .cmp_irq(cmp_irq), .seq_irq(seq_irq),
        .res_we(res_we), .seq_abort(seq_abort), .seq_restart(seq_restart)
    );

    task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic strobes_off();
        conv_done = 0; cmp_match = 0; conv_last = 0; seq_start = 0;
        flag_wr = 0; reg_rd = 0; reg_wr = 0;
        conv_idx = '0; reg_idx = '0; flag_wdata = '0;
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
        strobes_off();
    endtask

    task automatic convert(input int idx, input logic match, input logic last);
        conv_done = 1; conv_idx = IW'(idx); cmp_match = match; conv_last = last;
        step();
    endtask

    task automatic wipe();
        fast_clr = 0; flag_wr = 1; flag_wdata = '1;
        step();
    endtask

    initial begin
        #2_000_000;
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        rst_n = 0;
        strobes_off();
        cmp_en = '0; fast_clr = 0; cmp_ie = 0; seq_ie = 0;
        stop_mode = 0; cont_in_stop = 0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        #1;
        // R1 reset state
        chk(flags, 0, "R1 flags");
        chk({seq_flag, cmp_irq, seq_irq, seq_abort, seq_restart}, 0, "R1 misc");
        @(negedge clk);

        // R2 set per slot, accumulate
        exp_f = '0;
        for (int n = 0; n < N; n++) begin
            conv_done = 1; conv_idx = IW'(n); #1;
            chk(res_we, 1, "R2 res_we");
            step();
            exp_f[n] = 1'b1;
            chk(flags, exp_f, "R2 set");
        end

        // R3 register access ignored in legacy mode
        for (int n = 0; n < N; n++) begin
            reg_rd = 1; reg_wr = 1; reg_idx = IW'(n);
            step();
            chk(flags, 16'hFFFF, "R3 access ignored");
        end
        flag_wr = 1; flag_wdata = 16'hA5C3;
        step();
        chk(flags, 16'hFFFF & ~16'hA5C3, "R3 w1c");
        flag_wr = 1; flag_wdata = ~16'hA5C3;
        step();
        chk(flags, 0, "R3 w1c rest");

        // R4 fast clear, compare off: read clears
        for (int n = 0; n < N; n++) convert(n, 0, 0);
        fast_clr = 1; exp_f = 16'hFFFF;
        for (int n = 0; n < N; n++) begin
            reg_wr = 1; reg_idx = IW'(n); flag_wr = 1; flag_wdata = '1;
            step();
            chk(flags, exp_f, "R4 write ignored");
            reg_rd = 1; reg_idx = IW'(n);
            step();
            exp_f[n] = 1'b0;
            chk(flags, exp_f, "R4 read clears");
        end

        // R5 fast clear, compare on: write clears
        cmp_en = '1;
        for (int n = 0; n < N; n++) convert(n, 1, 0);
        exp_f = 16'hFFFF;
        for (int n = 0; n < N; n++) begin
            reg_rd = 1; reg_idx = IW'(n);
            step();
            chk(flags, exp_f, "R5 read ignored");
            reg_wr = 1; reg_idx = IW'(n);
            step();
            exp_f[n] = 1'b0;
            chk(flags, exp_f, "R5 write clears");
        end

        // R6 compare gating, R9 compare interrupt
        fast_clr = 0; cmp_en = 16'h0F0F; cmp_ie = 1; exp_f = '0;
        for (int n = 0; n < N; n++) begin
            convert(n, 0, 0);
            if (!cmp_en[n]) exp_f[n] = 1'b1;
            chk(flags, exp_f, "R6 miss");
        end
        chk(cmp_irq, 0, "R9 cmp_irq non-compare flags");
        for (int n = 0; n < N; n++) begin
            convert(n, 1, 0);
            exp_f[n] = 1'b1;
            chk(flags, exp_f, "R6 match");
        end
        chk(cmp_irq, 1, "R9 cmp_irq set");
        cmp_ie = 0; #1;
        chk(cmp_irq, 0, "R9 cmp_irq disabled");
        cmp_ie = 1;
        flag_wr = 1; flag_wdata = 16'h0F0F;
        step();
        chk(cmp_irq, 0, "R9 cmp_irq after clear");
        wipe();

        // R7 set beats clear
        cmp_en = '0;
        for (int n = 0; n < N; n += 5) begin
            wipe();
            conv_done = 1; conv_idx = IW'(n); flag_wr = 1; flag_wdata = '1;
            step();
            chk(flags, 16'(1) << n, "R7 legacy");
        end
        fast_clr = 1;
        conv_done = 1; conv_idx = 4'd2; reg_rd = 1; reg_idx = 4'd2;
        step();
        chk(flags[2], 1, "R7 fast");
        wipe();

        // R8 sequence flag, R9 sequence interrupt
        seq_ie = 1;
        seq_start = 1; step();
        chk(seq_flag, 0, "R8 start");
        convert(3, 0, 0);
        chk(seq_flag, 0, "R8 not last");
        chk(seq_irq, 0, "R9 seq_irq idle");
        convert(4, 0, 1);
        chk(seq_flag, 1, "R8 last");
        chk(seq_irq, 1, "R9 seq_irq");
        seq_ie = 0; #1;
        chk(seq_irq, 0, "R9 seq_irq disabled");
        seq_ie = 1;
        seq_start = 1; step();
        chk(seq_flag, 0, "R8 restart clears");
        seq_start = 1; conv_done = 1; conv_idx = 4'd1; conv_last = 1;
        step();
        chk(seq_flag, 1, "R8 set wins");
        seq_start = 1; step();
        wipe();

        // R10/R12 continue in stop
        cont_in_stop = 1; stop_mode = 1;
        step();                                   // Enter
        conv_done = 1; conv_idx = 4'd5; conv_last = 1; #1;
        chk(res_we, 0, "R10 enter res_we");
        step();                                   // StopConvert
        chk(flags, 0, "R10 enter flags");
        chk(seq_flag, 0, "R10 enter seq");
        conv_done = 1; conv_idx = 4'd6; #1;
        chk(res_we, 1, "R12 stop res_we");
        step();
        chk(flags, 16'h0040, "R12 stop flag");
        stop_mode = 0;
        step();                                   // Exit
        conv_done = 1; conv_idx = 4'd7; conv_last = 1; #1;
        chk(res_we, 0, "R10 exit res_we");
        step();                                   // Run
        chk(flags, 16'h0040, "R10 exit flags");
        chk(seq_flag, 0, "R10 exit seq");
        convert(8, 0, 0);
        chk(flags, 16'h0140, "R2 back in run");
        wipe();

        // R11 halt with active sequence
        cont_in_stop = 0;
        seq_start = 1; step();
        stop_mode = 1;
        step();                                   // Enter
        #1;
        chk(seq_abort, 1, "R11 abort");
        step();                                   // StopHalt
        chk(seq_abort, 0, "R11 abort pulse");
        conv_done = 1; conv_idx = 4'd9; #1;
        chk(res_we, 0, "R11 halt res_we");
        step();
        chk(flags, 0, "R11 halt flags");
        stop_mode = 0;
        step();                                   // Exit
        chk(seq_restart, 1, "R11 restart");
        step();                                   // Run
        chk(seq_restart, 0, "R11 restart pulse");

        // R11 halt without active sequence
        stop_mode = 1;
        step(); #1;
        chk(seq_abort, 0, "R11 idle no abort");
        step();
        stop_mode = 0;
        step();
        chk(seq_restart, 0, "R11 idle no restart");
        step();

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule